// File: doc/BRIEF.md
# Ping-Pong Two-Run Merge Unit

This block takes two ascending runs of equal length and emits them as one ascending run of twice that length, one element per clock. Each input lane (A and B) streams its run into a lane FIFO. Every output element is decided by a single comparison of the two FIFO heads. Only the FIFO that supplied the element is popped. Once one run has been fully consumed, the rest of the other run is passed out in order with no further comparison.

The lane FIFOs are duplicated into two banks that are used in alternation. While one bank pair is being merged, both lanes can already load the next run pair into the other bank. A merge stage can therefore hand its output straight to a following stage with twice the run length, and both stages work at the same time without a producer overwriting a run that its consumer has not finished reading.

The controller is a four-state machine:
- `MS_WAIT` idles until both FIFOs of the current bank hold a complete run, then takes transition T1 to `MS_MERGE`.
- `MS_MERGE` compares the two heads on every accepted output. When lane A's last element leaves, it takes T2 to `MS_DRAIN_B`. When lane B's last element leaves, it takes T3 to `MS_DRAIN_A`.
- `MS_DRAIN_A` and `MS_DRAIN_B` forward the leftover lane. On the final element of the run pair they take T4 back to `MS_WAIT`, and T4 also swaps the merge bank.

Top module: `pingpong_merge`

## Requirements
- R1: Straight after reset `out_valid` and `out_last` are 0, and `a_ready` and `b_ready` are both 1.
- R2: No output is offered until both lanes have delivered a complete run of `RUN_LEN` elements into the current bank. A full lane A with an empty lane B keeps `out_valid` at 0.
- R3: While both runs still have elements, the output is lane A's head if it is strictly less than lane B's head (unsigned compare), otherwise lane B's head. Each run pair therefore comes out in ascending order.
- R4: After all `RUN_LEN` elements of one lane have been output, the remaining elements of the other lane are output in their original order.
- R5: Each run pair yields exactly 2·`RUN_LEN` accepted outputs. `out_last` is 1 together with the 2·`RUN_LEN`-th of them and only then.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_data` stays unchanged and no element is consumed.
- R7: With `out_ready` held at 1, the 2·`RUN_LEN` outputs of a run pair are accepted on consecutive clock cycles.
- R8: Each lane fills bank 0 and bank 1 alternately, switching after every `RUN_LEN` accepted elements. A second run pair is accepted while the first is still waiting to be merged. With both banks holding unmerged runs, `a_ready` and `b_ready` are 0. Run pairs are output in the order they were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Lane A element present |
| a_data | input | DATA_W | Lane A element |
| a_ready | output | 1 | Lane A element accepted this cycle when valid |
| b_valid | input | 1 | Lane B element present |
| b_data | input | DATA_W | Lane B element |
| b_ready | output | 1 | Lane B element accepted this cycle when valid |
| out_valid | output | 1 | Merged element present |
| out_data | output | DATA_W | Merged element |
| out_ready | input | 1 | Downstream accepts the merged element |
| out_last | output | 1 | Marks the final element of a merged run pair |

## Verification
An input element is written at the clock edge where its valid and ready are both high. The bank counts it from that edge on. The state machine sees a full bank pair on the next edge, so `out_valid` rises one cycle after the last input write. From then on one element leaves per edge while `out_ready` is high, and `out_last` accompanies the final one in the same cycle.

Because the start latency depends on when loading ends, the bench does not time the start of a run. It records every accepted output at the falling edge, together with its cycle number, and checks values, the `out_last` position and cycle adjacency against each record. The stall and ping-pong checks sample `out_valid`, `out_data` and the ready outputs at a falling edge after several full cycles with the output blocked.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        MS_WAIT    = 2'd0,
        MS_MERGE   = 2'd1,
        MS_DRAIN_A = 2'd2,
        MS_DRAIN_B = 2'd3
    } merge_state_e;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/pm_fifo.sv
module pm_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_en) begin
                wptr_q <= bump(wptr_q);
            end
            if (rd_en) begin
                rptr_q <= bump(rptr_q);
            end
            unique case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rd_data = mem[rptr_q];
    assign count   = cnt_q;

endmodule

// File: rtl/pm_loader.sv
module pm_loader #(
    parameter int RUN_LEN = 4,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [1:0][CNT_W-1:0] bank_cnt,
    input  logic                  merge_busy,
    input  logic                  merge_bank,
    output logic [1:0]            wr_en
);

    logic             fill_bank_q;
    logic [CNT_W-1:0] wcnt_q;
    logic             accept;

    always_comb begin
        in_ready = (bank_cnt[fill_bank_q] < CNT_W'(RUN_LEN))
                && !(merge_busy && (merge_bank == fill_bank_q));
        accept   = in_valid && in_ready;
        wr_en    = '0;
        wr_en[fill_bank_q] = accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_bank_q <= 1'b0;
            wcnt_q      <= '0;
        end else if (accept) begin
            if (wcnt_q == CNT_W'(RUN_LEN - 1)) begin
                wcnt_q      <= '0;
                fill_bank_q <= ~fill_bank_q;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import pm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RUN_LEN = 4,
    localparam int CNT_W  = $clog2(RUN_LEN + 1),
    localparam int EMIT_W = $clog2(2 * RUN_LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0][CNT_W-1:0]  cnt_a,
    input  logic [1:0][CNT_W-1:0]  cnt_b,
    input  logic [1:0][DATA_W-1:0] head_a,
    input  logic [1:0][DATA_W-1:0] head_b,
    input  logic                   out_ready,
    output logic [1:0]             pop_a,
    output logic [1:0]             pop_b,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data,
    output logic                   out_last,
    output logic                   merge_busy,
    output logic                   merge_bank
);

    localparam logic [EMIT_W-1:0] LAST_IDX = EMIT_W'(2 * RUN_LEN - 1);
    localparam logic [CNT_W-1:0]  END_IDX  = CNT_W'(RUN_LEN - 1);

    merge_state_e      state_q, state_d;
    logic              mb_q;
    logic [CNT_W-1:0]  taken_a_q;
    logic [CNT_W-1:0]  taken_b_q;
    logic [EMIT_W-1:0] emit_q;

    logic [DATA_W-1:0] ha, hb;
    logic              bank_full;
    logic              take_a;
    logic              fire;
    logic              run_end;

    assign ha        = head_a[mb_q];
    assign hb        = head_b[mb_q];
    assign bank_full = (cnt_a[mb_q] == CNT_W'(RUN_LEN))
                    && (cnt_b[mb_q] == CNT_W'(RUN_LEN));

    // Output decode
    always_comb begin
        out_valid = 1'b0;
        take_a    = 1'b0;
        unique case (state_q)
            MS_WAIT: begin
                out_valid = 1'b0;
            end
            MS_MERGE: begin
                out_valid = 1'b1;
                take_a    = (ha < hb);
            end
            MS_DRAIN_A: begin
                out_valid = 1'b1;
                take_a    = 1'b1;
            end
            MS_DRAIN_B: begin
                out_valid = 1'b1;
                take_a    = 1'b0;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
        fire       = out_valid && out_ready;
        run_end    = fire && (emit_q == LAST_IDX);
        out_data   = take_a ? ha : hb;
        out_last   = out_valid && (emit_q == LAST_IDX);
        pop_a      = '0;
        pop_b      = '0;
        pop_a[mb_q] = fire && take_a;
        pop_b[mb_q] = fire && !take_a;
        merge_busy = (state_q != MS_WAIT);
        merge_bank = mb_q;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_WAIT: begin
                if (bank_full) begin
                    state_d = MS_MERGE;                  // T1
                end
            end
            MS_MERGE: begin
                if (fire && take_a && (taken_a_q == END_IDX)) begin
                    state_d = MS_DRAIN_B;                // T2
                end else if (fire && !take_a && (taken_b_q == END_IDX)) begin
                    state_d = MS_DRAIN_A;                // T3
                end
            end
            MS_DRAIN_A, MS_DRAIN_B: begin
                if (run_end) begin
                    state_d = MS_WAIT;                   // T4
                end
            end
            default: begin
                state_d = MS_WAIT;
            end
        endcase
    end

    // State register and run counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= MS_WAIT;
            mb_q      <= 1'b0;
            taken_a_q <= '0;
            taken_b_q <= '0;
            emit_q    <= '0;
        end else begin
            state_q <= state_d;
            if (run_end) begin
                mb_q      <= ~mb_q;
                taken_a_q <= '0;
                taken_b_q <= '0;
                emit_q    <= '0;
            end else if (fire) begin
                emit_q <= emit_q + 1'b1;
                if (take_a) begin
                    taken_a_q <= taken_a_q + 1'b1;
                end else begin
                    taken_b_q <= taken_b_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pingpong_merge.sv
module pingpong_merge
    import pm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RUN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_ready,
    input  logic              b_valid,
    input  logic [DATA_W-1:0] b_data,
    output logic              b_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              out_last
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [1:0][CNT_W-1:0]  cnt_a, cnt_b;
    logic [1:0][DATA_W-1:0] head_a, head_b;
    logic [1:0]             wr_a, wr_b;
    logic [1:0]             pop_a, pop_b;
    logic                   merge_busy;
    logic                   merge_bank;

    for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_bank
        pm_fifo #(.DATA_W(DATA_W), .DEPTH(RUN_LEN)) u_fifo_a (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_a[bk]),
            .wr_data (a_data),
            .rd_en   (pop_a[bk]),
            .rd_data (head_a[bk]),
            .count   (cnt_a[bk])
        );
        pm_fifo #(.DATA_W(DATA_W), .DEPTH(RUN_LEN)) u_fifo_b (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_b[bk]),
            .wr_data (b_data),
            .rd_en   (pop_b[bk]),
            .rd_data (head_b[bk]),
            .count   (cnt_b[bk])
        );
    end

    pm_loader #(.RUN_LEN(RUN_LEN)) u_load_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (a_valid),
        .in_ready   (a_ready),
        .bank_cnt   (cnt_a),
        .merge_busy (merge_busy),
        .merge_bank (merge_bank),
        .wr_en      (wr_a)
    );

    pm_loader #(.RUN_LEN(RUN_LEN)) u_load_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (b_valid),
        .in_ready   (b_ready),
        .bank_cnt   (cnt_b),
        .merge_busy (merge_busy),
        .merge_bank (merge_bank),
        .wr_en      (wr_b)
    );

    pm_ctrl #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_a      (cnt_a),
        .cnt_b      (cnt_b),
        .head_a     (head_a),
        .head_b     (head_b),
        .out_ready  (out_ready),
        .pop_a      (pop_a),
        .pop_b      (pop_b),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .merge_busy (merge_busy),
        .merge_bank (merge_bank)
    );

endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int DATA_W  = 8,
    parameter int RUN_LEN = 4,
    localparam int EMIT_W = $clog2(2 * RUN_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_ready,
    input logic              b_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready,
    input logic              out_last
);

    logic              seen_rst_q;
    logic [EMIT_W-1:0] n_q;
    logic [DATA_W-1:0] prev_q;
    logic              have_prev_q;
    logic              fire;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst_q  <= 1'b1;
            n_q         <= '0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (fire) begin
            if (out_last) begin
                n_q         <= '0;
                have_prev_q <= 1'b0;
            end else begin
                n_q         <= n_q + 1'b1;
                prev_q      <= out_data;
                have_prev_q <= 1'b1;
            end
        end
    end

    // R1: right after reset nothing is offered and both lanes are open
    assert_reset_idle_R1: assert property (@(posedge clk)
        disable iff (!rst_n) (seen_rst_q && $rose(rst_n)) |-> (!out_valid && a_ready && b_ready));

    // R3: the merged stream does not descend within a run pair
    assert_ascending_R3: assert property (@(posedge clk)
        disable iff (!rst_n) (fire && have_prev_q) |-> (out_data >= prev_q));

    // R5: the last flag only comes with a valid element
    assert_last_valid_R5: assert property (@(posedge clk)
        disable iff (!rst_n) out_last |-> out_valid);

    // R5: the last flag marks the 2N-th accepted element exactly
    assert_run_length_R5: assert property (@(posedge clk)
        disable iff (!rst_n) fire |-> (out_last == (n_q == EMIT_W'(2 * RUN_LEN - 1))));

    // R6: a blocked output holds its element
    assert_stall_hold_R6: assert property (@(posedge clk)
        disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind pingpong_merge pm_checker #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_pm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_ready   (a_ready),
    .b_ready   (b_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .out_last  (out_last)
);

// File: tb/tb_pingpong_merge.sv
module tb_pingpong_merge;

    localparam int DW = 8;
    localparam int N  = 4;
    localparam int NV = 5;

    // lane A run, lane B run; element 0 in the low byte
    localparam logic [31:0] VEC_A [NV] = '{32'h09060401, 32'h04030201, 32'h32281E14,
                                           32'h07070505, 32'hFFFF0000};
    localparam logic [31:0] VEC_B [NV] = '{32'h08070302, 32'h0D0C0B0A, 32'h08070605,
                                           32'h09070705, 32'hFFFF8000};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          a_valid, b_valid, out_ready;
    logic [DW-1:0] a_data, b_data;
    logic          a_ready, b_ready, out_valid, out_last;
    logic [DW-1:0] out_data;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int rec_n = 0;
    logic [DW-1:0] rec_data [64];
    logic          rec_last [64];
    int            rec_cyc  [64];

    always #2 clk = ~clk;

    pingpong_merge #(.DATA_W(DW), .RUN_LEN(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
        .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .out_last(out_last)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && out_valid && out_ready && rec_n < 64) begin
            rec_data[rec_n] = out_data;
            rec_last[rec_n] = out_last;
            rec_cyc[rec_n]  = cyc;
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sorted_pair(input logic [31:0] ra, input logic [31:0] rb);
        logic [7:0] v [8];
        logic [7:0] t;
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            v[i]     = ra[8*i +: 8];
            v[i + 4] = rb[8*i +: 8];
        end
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 7 - i; j++) begin
                if (v[j] > v[j + 1]) begin
                    t = v[j]; v[j] = v[j + 1]; v[j + 1] = t;
                end
            end
        end
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[i];
        return r;
    endfunction

    task automatic push_lane(input bit lane_b, input logic [31:0] run);
        for (int i = 0; i < N; i++) begin
            @(posedge clk); #1;
            if (lane_b) begin b_valid = 1'b1; b_data = run[8*i +: 8]; end
            else        begin a_valid = 1'b1; a_data = run[8*i +: 8]; end
            @(negedge clk);
            while (!(lane_b ? b_ready : a_ready)) @(negedge clk);
        end
        @(posedge clk); #1;
        if (lane_b) b_valid = 1'b0; else a_valid = 1'b0;
    endtask

    task automatic wait_recs(input int target);
        while (rec_n < target) @(negedge clk);
    endtask

    // R3/R4 data, R5 last flag, R7 back-to-back acceptance
    task automatic check_run(input int base, input logic [63:0] exp, input string dreq);
        for (int i = 0; i < 2 * N; i++) begin
            check(dreq, "merged element", int'(rec_data[base + i]), int'(exp[8*i +: 8]));
            check("R5", "last flag", int'(rec_last[base + i]), (i == 2 * N - 1) ? 1 : 0);
        end
        check("R7", "cycles spanned by run", rec_cyc[base + 2*N - 1] - rec_cyc[base], 2 * N - 1);
    endtask

    initial begin
        #(4 * 150000);
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        logic [DW-1:0] held;
        rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0; out_ready = 1'b0;
        a_data = '0; b_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_last after reset", int'(out_last), 0);
        check("R1", "a_ready after reset", int'(a_ready), 1);
        check("R1", "b_ready after reset", int'(b_ready), 1);

        // Vector table: one run pair per entry, output unblocked
        out_ready = 1'b1;
        base = 0;
        for (int k = 0; k < NV; k++) begin
            push_lane(1'b0, VEC_A[k]);
            if (k == 0) begin
                repeat (5) @(negedge clk);
                check("R2", "out_valid with lane B empty", int'(out_valid), 0);
                check("R2", "outputs with lane B empty", rec_n, 0);
            end
            push_lane(1'b1, VEC_B[k]);
            wait_recs(base + 2 * N);
            check_run(base, sorted_pair(VEC_A[k], VEC_B[k]), (k == 1 || k == 2) ? "R4" : "R3");
            base = base + 2 * N;
        end

        // Stall: output blocked while a complete pair is ready
        @(posedge clk); #1 out_ready = 1'b0;
        fork
            push_lane(1'b0, VEC_A[2]);
            push_lane(1'b1, VEC_B[2]);
        join
        repeat (4) @(negedge clk);
        check("R6", "out_valid while blocked", int'(out_valid), 1);
        check("R6", "head while blocked", int'(out_data), 5);
        held = out_data;
        repeat (3) @(negedge clk);
        check("R6", "data held while blocked", int'(out_data), int'(held));
        check("R6", "nothing accepted while blocked", rec_n, base);
        @(posedge clk); #1 out_ready = 1'b1;
        wait_recs(base + 2 * N);
        check_run(base, sorted_pair(VEC_A[2], VEC_B[2]), "R4");
        base = base + 2 * N;

        // Ping-pong: two pairs loaded before either is merged
        @(posedge clk); #1 out_ready = 1'b0;
        fork
            push_lane(1'b0, VEC_A[0]);
            push_lane(1'b1, VEC_B[0]);
        join
        fork
            push_lane(1'b0, VEC_A[3]);
            push_lane(1'b1, VEC_B[3]);
        join
        repeat (2) @(negedge clk);
        check("R8", "a_ready with both banks full", int'(a_ready), 0);
        check("R8", "b_ready with both banks full", int'(b_ready), 0);
        check("R8", "nothing accepted before release", rec_n, base);
        @(posedge clk); #1 out_ready = 1'b1;
        wait_recs(base + 4 * N);
        check_run(base, sorted_pair(VEC_A[0], VEC_B[0]), "R8");
        check_run(base + 2 * N, sorted_pair(VEC_A[3], VEC_B[3]), "R8");
        repeat (3) @(negedge clk);
        check("R8", "lanes open after both pairs drain", int'(a_ready && b_ready), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule